// File: doc/BRIEF.md
# Prioritized vectored interrupt acceptor

This block sits next to one processor core and collects interrupt vectors addressed to it. Every one of the 256 vectors has a pending bit, an in-service bit and a trigger-kind bit. The number of a vector is also its priority: a larger number wins, and vectors fall into priority classes of sixteen, taken from the upper nibble. The block combines a software-set task priority with the class of the highest vector in service to form a processor priority. It raises its line to the core only when the best pending vector belongs to a strictly higher class.

The core acknowledges with a one-cycle pulse. In that same cycle the block returns the vector to run and moves it from pending to in service. When the task priority masks the vector, the block returns the low byte of the spurious register instead. Software retires the current handler by writing the end-of-interrupt register. A 32-bit register port, indexed by address bits 11:4, exposes task priority, processor priority, the spurious/enable register, the three 256-bit vectors as eight words each, and an error status word.

Top module: `vac_core`

## Requirements
- R1: A cycle with `in_valid` high sets the pending bit of `in_vector`. The same cycle writes its trigger bit from `in_level` (1 = level, 0 = edge).
- R2: The processor priority (read at index 0x0A) equals the task priority when the task-priority class (bits 7:4) is at least the class of the highest in-service vector. Otherwise it equals that class shifted left by 4. With nothing in service, that class counts as 0.
- R3: `irq` is high only when bit 8 of the spurious register is set and some vector is pending. The class of the highest pending vector must also exceed the processor-priority class, unless the processor priority is zero.
- R4: An acknowledge that is taken returns the highest pending vector on `ack_vector` in the same cycle, with `ack_hit` high. It clears that vector's pending bit and sets its in-service bit.
- R5: If the task priority is nonzero and the highest pending vector is at or below it, an acknowledge clears the pending bit and leaves in-service unchanged. It returns spurious-register bits 7:0.
- R6: An acknowledge while bit 8 of the spurious register is clear, or while nothing is pending, is ignored: `ack_hit` and `ack_vector` stay 0 and no state changes.
- R7: A write to index 0x0B clears the highest set in-service bit.
- R8: Index 0x08 holds the 8-bit task priority and index 0x0F the 9-bit spurious register. Words k=0..7 of in-service, trigger and pending sit at indices 0x10+k, 0x18+k and 0x20+k, with vector 32k+b at bit b. Writes to processor priority, pending, in-service, trigger and error words are ignored.
- R9: A read or write of an undefined index sets bit 7 of the error word at index 0x28. The same applies to a read of index 0x0B. Such a read returns 0.
- R10: Reset clears pending, in-service, trigger, task priority and error. It sets the spurious register to 0x0FF, which leaves the block disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accept a vector this cycle |
| in_vector | input | 8 | Vector being accepted |
| in_level | input | 1 | Trigger kind of the accepted vector, 1 = level |
| ack | input | 1 | Acknowledge pulse from the core |
| ack_hit | output | 1 | Acknowledge taken this cycle |
| ack_vector | output | 8 | Vector returned for the acknowledge |
| irq | output | 1 | Interrupt request to the core |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte address, index in bits 11:4 |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of `reg_rd` |

## Verification
The bench puts a lower-class vector behind one in service. A design that compared whole vectors instead of classes, or that ignored in-service when forming the processor priority, would raise `irq` there. It sets a task priority whose class is at least that of the in-service vector, where a wrong choice of branch reads back the in-service class instead of the full task value. It acknowledges a vector masked by task priority, which a faulty block would put into service instead of returning the spurious byte. It also acknowledges while disabled and while nothing is pending, and retires two nested handlers in order; a block that retired the lowest in-service bit would leave the wrong one active.

// File: rtl/vac_pkg.sv
package vac_pkg;
    localparam int NUM_VEC   = 256;
    localparam int VEC_W     = $clog2(NUM_VEC);
    localparam int WORD_W    = 32;
    localparam int NUM_WORDS = NUM_VEC / WORD_W;
    localparam int WSEL_W    = $clog2(NUM_WORDS);
    localparam int ADDR_W    = 12;
    localparam int SPUR_W    = 9;
    localparam int EN_BIT    = 8;
    localparam int ERR_BIT   = 7;
    localparam logic [SPUR_W-1:0] SPUR_RST = 9'h0FF;

    typedef enum logic [3:0] {
        K_TPR, K_PPR, K_EOI, K_SPUR, K_ISR, K_TMR, K_IRR, K_ERR, K_BAD
    } reg_kind_e;

    typedef struct packed {
        logic             valid;
        logic [VEC_W-1:0] vec;
    } top_t;

    function automatic logic [3:0] class_of(input logic [VEC_W-1:0] v);
        return v[VEC_W-1 -: 4];
    endfunction

    function automatic reg_kind_e decode(input logic [7:0] idx);
        reg_kind_e k;
        k = K_BAD;
        if (idx == 8'h08)               k = K_TPR;
        else if (idx == 8'h0A)          k = K_PPR;
        else if (idx == 8'h0B)          k = K_EOI;
        else if (idx == 8'h0F)          k = K_SPUR;
        else if (idx[7:3] == 5'b00010)  k = K_ISR;
        else if (idx[7:3] == 5'b00011)  k = K_TMR;
        else if (idx[7:3] == 5'b00100)  k = K_IRR;
        else if (idx == 8'h28)          k = K_ERR;
        return k;
    endfunction
endpackage

// File: rtl/vac_msb_find.sv
module vac_msb_find #(
    parameter int W  = 256,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  bits,
    output logic          valid,
    output logic [IW-1:0] idx
);
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int i = 0; i < W; i++) begin
            if (bits[i]) begin
                valid = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/vac_prio.sv
module vac_prio
    import vac_pkg::*;
(
    input  logic             enable,
    input  logic [VEC_W-1:0] tpr,
    input  top_t             isr_top,
    input  top_t             irr_top,
    output logic [VEC_W-1:0] ppr,
    output logic             irq
);
    logic [3:0] isr_cls;

    always_comb begin
        isr_cls = isr_top.valid ? class_of(isr_top.vec) : 4'h0;
        if (class_of(tpr) >= isr_cls) ppr = tpr;
        else                          ppr = {isr_cls, 4'h0};
        irq = enable && irr_top.valid &&
              ((ppr == '0) || (class_of(irr_top.vec) > class_of(ppr)));
    end
endmodule

// File: rtl/vac_core.sv
module vac_core
    import vac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [VEC_W-1:0]  in_vector,
    input  logic              in_level,
    input  logic              ack,
    output logic              ack_hit,
    output logic [VEC_W-1:0]  ack_vector,
    output logic              irq,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata
);
    logic [NUM_VEC-1:0] irr_q, isr_q, tmr_q;
    logic [NUM_VEC-1:0] irr_n, isr_n, tmr_n;
    logic [VEC_W-1:0]   tpr_q;
    logic [SPUR_W-1:0]  spur_q;
    logic               err_q;

    top_t               irr_top, isr_top;
    logic [VEC_W-1:0]   ppr;
    reg_kind_e          kind;
    logic [WSEL_W-1:0]  wsel;
    logic               take, spurious, eoi, bad;

    vac_msb_find #(.W(NUM_VEC)) u_irr_find (
        .bits(irr_q), .valid(irr_top.valid), .idx(irr_top.vec)
    );
    vac_msb_find #(.W(NUM_VEC)) u_isr_find (
        .bits(isr_q), .valid(isr_top.valid), .idx(isr_top.vec)
    );
    vac_prio u_prio (
        .enable(spur_q[EN_BIT]), .tpr(tpr_q), .isr_top(isr_top),
        .irr_top(irr_top), .ppr(ppr), .irq(irq)
    );

    always_comb begin
        kind     = decode(reg_addr[ADDR_W-1:4]);
        wsel     = reg_addr[4 +: WSEL_W];
        take     = ack && spur_q[EN_BIT] && irr_top.valid;
        spurious = take && (tpr_q != '0) && (irr_top.vec <= tpr_q);
        eoi      = reg_wr && (kind == K_EOI) && isr_top.valid;
        bad      = (reg_wr && kind == K_BAD) ||
                   (reg_rd && (kind == K_BAD || kind == K_EOI));
        ack_hit    = take;
        ack_vector = !take ? '0 : (spurious ? spur_q[VEC_W-1:0] : irr_top.vec);

        irr_n = irr_q;
        isr_n = isr_q;
        tmr_n = tmr_q;
        if (take)               irr_n[irr_top.vec] = 1'b0;
        if (in_valid)           irr_n[in_vector]   = 1'b1;
        if (in_valid)           tmr_n[in_vector]   = in_level;
        if (eoi)                isr_n[isr_top.vec] = 1'b0;
        if (take && !spurious)  isr_n[irr_top.vec] = 1'b1;

        reg_rdata = '0;
        if (reg_rd) begin
            case (kind)
                K_TPR:   reg_rdata = WORD_W'(tpr_q);
                K_PPR:   reg_rdata = WORD_W'(ppr);
                K_SPUR:  reg_rdata = WORD_W'(spur_q);
                K_ISR:   reg_rdata = isr_q[wsel*WORD_W +: WORD_W];
                K_TMR:   reg_rdata = tmr_q[wsel*WORD_W +: WORD_W];
                K_IRR:   reg_rdata = irr_q[wsel*WORD_W +: WORD_W];
                K_ERR:   reg_rdata = WORD_W'(err_q) << ERR_BIT;
                default: reg_rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irr_q  <= '0;
            isr_q  <= '0;
            tmr_q  <= '0;
            tpr_q  <= '0;
            spur_q <= SPUR_RST;
            err_q  <= 1'b0;
        end else begin
            irr_q <= irr_n;
            isr_q <= isr_n;
            tmr_q <= tmr_n;
            if (reg_wr && kind == K_TPR)  tpr_q  <= reg_wdata[VEC_W-1:0];
            if (reg_wr && kind == K_SPUR) spur_q <= reg_wdata[SPUR_W-1:0];
            if (bad)                      err_q  <= 1'b1;
        end
    end
endmodule

// File: rtl/vac_core_chk.sv
module vac_core_chk
    import vac_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic [VEC_W-1:0]   in_vector,
    input logic               in_level,
    input logic               ack,
    input logic               ack_hit,
    input logic [VEC_W-1:0]   ack_vector,
    input logic               irq,
    input logic               reg_wr,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [NUM_VEC-1:0] irr_q,
    input logic [NUM_VEC-1:0] isr_q,
    input logic [NUM_VEC-1:0] tmr_q,
    input logic [VEC_W-1:0]   tpr_q,
    input logic [SPUR_W-1:0]  spur_q
);
    a_r1_accept_pending: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> irr_q[$past(in_vector)]);

    a_r1_trigger_kind: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> tmr_q[$past(in_vector)] == $past(in_level));

    a_r3_irq_gated: assert property (@(posedge clk) disable iff (rst)
        irq |-> spur_q[EN_BIT] && (|irr_q));

    a_r4_into_service: assert property (@(posedge clk) disable iff (rst)
        ack_hit && (tpr_q == '0) |=> isr_q[$past(ack_vector)]);

    a_r6_ack_when_off: assert property (@(posedge clk) disable iff (rst)
        ack && !spur_q[EN_BIT] |-> !ack_hit && ack_vector == '0);

    a_r7_eoi_retires_one: assert property (@(posedge clk) disable iff (rst)
        reg_wr && reg_addr[ADDR_W-1:4] == 8'h0B && (|isr_q) && !ack_hit
        |=> $countones(isr_q) == $countones($past(isr_q)) - 1);

    a_r10_reset_state: assert property (@(posedge clk)
        rst |=> spur_q == SPUR_RST && irr_q == '0 && isr_q == '0 && tpr_q == '0);
endmodule

bind vac_core vac_core_chk u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_vector(in_vector),
    .in_level(in_level), .ack(ack), .ack_hit(ack_hit), .ack_vector(ack_vector),
    .irq(irq), .reg_wr(reg_wr), .reg_addr(reg_addr), .irr_q(irr_q),
    .isr_q(isr_q), .tmr_q(tmr_q), .tpr_q(tpr_q), .spur_q(spur_q)
);

// File: tb/vac_core_bench.sv
module vac_core_bench;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_vector = '0;
    logic        in_level = 1'b0;
    logic        ack = 1'b0;
    logic        ack_hit;
    logic [7:0]  ack_vector;
    logic        irq;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    vac_core u_vac_core (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_vector(in_vector),
        .in_level(in_level), .ack(ack), .ack_hit(ack_hit), .ack_vector(ack_vector),
        .irq(irq), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [7:0] idx, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = {idx, 4'h0}; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] idx, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = {idx, 4'h0};
        #(CLK_P/4);
        d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic accept(input logic [7:0] v, input logic lvl);
        @(negedge clk);
        in_valid = 1'b1; in_vector = v; in_level = lvl;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic do_ack(output logic hit, output logic [7:0] v);
        @(negedge clk);
        ack = 1'b1;
        #(CLK_P/4);
        hit = ack_hit; v = ack_vector;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic t_reset_state();
        logic [31:0] d;
        do_reset();
        rd(8'h0F, d); chk("R10 spurious after reset", d, 32'h0FF);
        rd(8'h08, d); chk("R10 task priority after reset", d, 32'h0);
        rd(8'h22, d); chk("R10 pending word after reset", d, 32'h0);
        rd(8'h28, d); chk("R10 error word after reset", d, 32'h0);
        chk("R10 irq after reset", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_accept();
        logic [31:0] d;
        accept(8'h31, 1'b0);
        accept(8'h45, 1'b1);
        rd(8'h21, d); chk("R1 pending word1", d, 32'h0002_0000);
        rd(8'h22, d); chk("R1 pending word2", d, 32'h0000_0020);
        rd(8'h1A, d); chk("R1 trigger word2 level", d, 32'h0000_0020);
        rd(8'h19, d); chk("R1 trigger word1 edge", d, 32'h0);
        chk("R3 irq low while disabled", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_enable_and_ack();
        logic [31:0] d;
        logic hit;
        logic [7:0] v;
        wr(8'h0F, 32'h1FF);
        rd(8'h0F, d); chk("R8 spurious keeps 9 bits", d, 32'h1FF);
        chk("R3 irq with zero priority", {31'b0, irq}, 32'h1);
        do_ack(hit, v);
        chk("R4 ack hit", {31'b0, hit}, 32'h1);
        chk("R4 ack returns highest", {24'b0, v}, 32'h45);
        rd(8'h12, d); chk("R4 in-service word2", d, 32'h0000_0020);
        rd(8'h22, d); chk("R4 pending cleared", d, 32'h0);
        rd(8'h0A, d); chk("R2 priority from in-service", d, 32'h40);
        chk("R3 lower class blocked", {31'b0, irq}, 32'h0);
        wr(8'h08, 32'h47);
        rd(8'h0A, d); chk("R2 priority from task", d, 32'h47);
        wr(8'h08, 32'h0);
    endtask

    task automatic t_nest_and_eoi();
        logic [31:0] d;
        logic hit;
        logic [7:0] v;
        accept(8'h52, 1'b0);
        chk("R3 higher class raises", {31'b0, irq}, 32'h1);
        do_ack(hit, v);
        chk("R4 nested ack", {24'b0, v}, 32'h52);
        rd(8'h0A, d); chk("R2 nested priority", d, 32'h50);
        wr(8'h0B, 32'h0);
        rd(8'h12, d); chk("R7 first retire keeps 0x45", d, 32'h0000_0020);
        rd(8'h0A, d); chk("R7 priority after first retire", d, 32'h40);
        wr(8'h0B, 32'h0);
        rd(8'h12, d); chk("R7 second retire", d, 32'h0);
        chk("R3 irq after all retired", {31'b0, irq}, 32'h1);
        wr(8'h08, 32'h30);
        chk("R3 same class as task blocked", {31'b0, irq}, 32'h0);
        wr(8'h08, 32'h20);
        chk("R3 above task class raises", {31'b0, irq}, 32'h1);
    endtask

    task automatic t_spurious();
        logic [31:0] d;
        logic hit;
        logic [7:0] v;
        wr(8'h0F, 32'h1E7);
        wr(8'h08, 32'h40);
        do_ack(hit, v);
        chk("R5 ack taken", {31'b0, hit}, 32'h1);
        chk("R5 spurious byte returned", {24'b0, v}, 32'hE7);
        rd(8'h21, d); chk("R5 pending cleared", d, 32'h0);
        rd(8'h11, d); chk("R5 not put in service", d, 32'h0);
    endtask

    task automatic t_ignored();
        logic [31:0] d;
        logic hit;
        logic [7:0] v;
        do_ack(hit, v);
        chk("R6 no pending no hit", {31'b0, hit}, 32'h0);
        chk("R6 no pending zero vector", {24'b0, v}, 32'h0);
        wr(8'h0F, 32'h0E7);
        wr(8'h08, 32'h0);
        accept(8'h60, 1'b0);
        do_ack(hit, v);
        chk("R6 disabled no hit", {31'b0, hit}, 32'h0);
        rd(8'h23, d); chk("R6 pending kept when disabled", d, 32'h1);
        rd(8'h13, d); chk("R6 nothing in service", d, 32'h0);
        chk("R3 irq low when disabled", {31'b0, irq}, 32'h0);
        wr(8'h23, 32'h0);
        rd(8'h23, d); chk("R8 pending word not writable", d, 32'h1);
        rd(8'h28, d); chk("R8 defined access no error", d, 32'h0);
    endtask

    task automatic t_bad_index();
        logic [31:0] d;
        rd(8'h05, d); chk("R9 undefined read returns 0", d, 32'h0);
        rd(8'h28, d); chk("R9 error bit set", d, 32'h80);
        do_reset();
        rd(8'h28, d); chk("R10 error cleared by reset", d, 32'h0);
        wr(8'h3C, 32'hFFFF_FFFF);
        rd(8'h28, d); chk("R9 undefined write sets error", d, 32'h80);
        do_reset();
        rd(8'h0B, d); chk("R9 read of retire index returns 0", d, 32'h0);
        rd(8'h28, d); chk("R9 read of retire index sets error", d, 32'h80);
        rd(8'h23, d); chk("R10 pending cleared by reset", d, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_accept();
        t_enable_and_ack();
        t_nest_and_eoi();
        t_spurious();
        t_ignored();
        t_bad_index();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule